// File: doc/BRIEF.md
# Masked Interrupt Request Collector

This block gathers interrupt requests from up to eight device lines into a pending register and combines them into one upstream interrupt. The host programs a mask in which a set bit blocks a line. Internally the block keeps the complement of that mask, so a set bit there means the line is enabled. The upstream line is high whenever at least one pending bit is also enabled. It is re-evaluated on every clock edge, so a mask write, an acknowledge or a device request change takes effect on the same edge that updates the registers.

Devices pulse `dev_set` to raise pending bits and `dev_clr` to withdraw them. The host acknowledges a request by writing its line number to the acknowledge address. The host can read back the mask and the pending register. A second, inert register slot stands in for a downstream controller. Its mask can be written and read, its status reads zero, and it never drives the interrupt.

Register map (3-bit address): 0 = primary mask, 1 = secondary mask, 2 = primary status, 3 = secondary status, 4 = acknowledge. Reads are combinational from the registers. Writes take effect on the rising clock edge.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, the enable mask, the pending register and the secondary mask are all zero, `irq_out` is low, and reads of address 0 and address 1 return 0xFF.
- R2: A host write to address 0 stores the bitwise complement of `host_wdata` as the enable mask. A read of address 0 returns the complement of the stored enable mask, which is the value last written.
- R3: After every rising edge, `irq_out` is high exactly when some pending bit is also enabled. This holds after mask writes, acknowledges and device requests alike.
- R4: Bits set in `dev_set` are ORed into the pending register on the clock edge.
- R5: Bits set in `dev_clr` are removed from the pending register on the clock edge.
- R6: When a bit is both set by `dev_set` and cleared in the same cycle, by `dev_clr` or by an acknowledge, the set wins and the bit ends pending.
- R7: A host write to address 4 clears the pending bit whose index is `host_wdata[3:0]`. Bits 7:4 of the data are ignored. An index of 8 or more clears nothing.
- R8: A read of address 2 returns the pending register. A read of address 3 always returns zero.
- R9: A host write to address 1 stores the data as written, and a read of address 1 returns its complement. The secondary mask never changes the enable mask, the pending register or `irq_out`.
- R10: Writes to addresses 5 to 7 change no state, and reads of addresses 4 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from `host_addr` |
| dev_set | input | 8 | Per-line request set pulses |
| dev_clr | input | 8 | Per-line request clear pulses |
| irq_out | output | 1 | Combined upstream interrupt |

## Verification
A corrupted enable or pending bit shows on `irq_out` on the edge where the mismatch arises, provided the other operand of that line is set. If it is not, the fault stays hidden until a status or mask read brings it out. The bench checks `irq_out` against its model after every edge, so a tracking fault is caught within one cycle. It reads status and mask often during random traffic, which bounds how long a masked-off corruption can stay latent. Directed cases cover the acknowledge index range, set-versus-clear collisions, and the secondary slot's isolation from the interrupt.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int N_LINES   = 8,
  parameter int ADDR_W    = 3,
  parameter int ACK_IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [N_LINES-1:0] host_wdata,
  output logic [N_LINES-1:0] host_rdata,
  input  logic [N_LINES-1:0] dev_set,
  input  logic [N_LINES-1:0] dev_clr,
  output logic               irq_out
);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK2 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT2 = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(4);

  logic [N_LINES-1:0] en_q, pend_q, mask2_q;
  logic [N_LINES-1:0] en_d, pend_d, ack_vec;
  logic               irq_q;
  logic [ACK_IDX_W-1:0] ack_idx;
  logic               ack_hit;

  assign ack_hit = host_we && (host_addr == A_ACK);
  assign ack_idx = host_wdata[ACK_IDX_W-1:0];

  for (genvar i = 0; i < N_LINES; i++) begin : g_ack
    assign ack_vec[i] = ack_hit && (ack_idx == ACK_IDX_W'(i));
  end

  assign en_d   = (host_we && host_addr == A_MASK) ? ~host_wdata : en_q;
  assign pend_d = (pend_q & ~dev_clr & ~ack_vec) | dev_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      pend_q  <= '0;
      mask2_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      irq_q  <= |(pend_d & en_d);
      if (host_we && host_addr == A_MASK2)
        mask2_q <= host_wdata;
    end
  end

  always_comb begin
    case (host_addr)
      A_MASK:  host_rdata = ~en_q;
      A_MASK2: host_rdata = ~mask2_q;
      A_STAT:  host_rdata = pend_q;
      A_STAT2: host_rdata = '0;
      default: host_rdata = '0;
    endcase
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int N_LINES   = 8,
  parameter int ADDR_W    = 3,
  parameter int ACK_IDX_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_we,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [N_LINES-1:0] host_wdata,
  input logic [N_LINES-1:0] dev_set,
  input logic [N_LINES-1:0] dev_clr,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] en,
  input logic               irq_out
);
  logic live;
  always_ff @(posedge clk) live <= rst_n;

  // R3
  irq_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    irq_out == |(pend & en));

  // R2
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == ADDR_W'(0)) |=> (en == ~$past(host_wdata)));

  // R4
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_set) |=> ((pend & $past(dev_set)) == $past(dev_set)));

  // R5
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dev_clr & ~dev_set)) |=> ((pend & $past(dev_clr & ~dev_set)) == '0));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == ADDR_W'(4) && dev_set == '0 &&
     host_wdata[ACK_IDX_W-1:0] < ACK_IDX_W'(N_LINES))
    |=> ((pend & (N_LINES'(1) << $past(host_wdata[ACK_IDX_W-1:0]))) == '0));

  // R9
  sec_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == ADDR_W'(1)) |=> $stable(en));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
  .N_LINES(N_LINES), .ADDR_W(ADDR_W), .ACK_IDX_W(ACK_IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .dev_set(dev_set), .dev_clr(dev_clr),
  .pend(pend_q), .en(en_q), .irq_out(irq_out)
);

// File: tb/irq_mask_ctrl_bench.sv
`timescale 1ns/100ps
module irq_mask_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [7:0] dev_set = '0;
  logic [7:0] dev_clr = '0;
  logic       irq_out;

  int vecs = 0;
  int errs = 0;
  logic [7:0] m_en = '0, m_pend = '0, m_sec = '0;
  int unsigned seed = 32'h1d5e_0a17;

  always #2 clk = ~clk;

  irq_mask_ctrl u_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_set(dev_set), .dev_clr(dev_clr), .irq_out(irq_out)
  );

  function automatic logic [7:0] ack_bits(logic we, logic [2:0] a, logic [7:0] d);
    if (we && a == 3'd4 && d[3:0] < 4'd8) return 8'(1) << d[3:0];
    return 8'h00;
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic we, logic [2:0] a, logic [7:0] d,
                     logic [7:0] s, logic [7:0] c, string tag);
    @(negedge clk);
    host_we = we; host_addr = a; host_wdata = d; dev_set = s; dev_clr = c;
    m_pend = (m_pend & ~c & ~ack_bits(we, a, d)) | s;
    if (we && a == 3'd0) m_en = ~d;
    if (we && a == 3'd1) m_sec = d;
    @(posedge clk);
    #0.5;
    host_we = 1'b0; dev_set = '0; dev_clr = '0;
    chk({7'd0, irq_out}, {7'd0, |(m_pend & m_en)}, tag);
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    host_we = 1'b0; host_addr = a;
    #0.5;
    chk(host_rdata, exp, tag);
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    // R1 reset state
    chk({7'd0, irq_out}, 8'd0, "R1 irq");
    rd(3'd0, 8'hFF, "R1 mask");
    rd(3'd1, 8'hFF, "R1 mask2");
    rd(3'd2, 8'h00, "R1 pend");

    // R4 set while masked-off: no irq; R2 unmask raises it
    cyc(1'b0, 3'd0, 8'h00, 8'h24, 8'h00, "R4 set");
    rd(3'd2, 8'h24, "R4 pend");
    cyc(1'b1, 3'd0, 8'hFB, 8'h00, 8'h00, "R2 R3 unmask");
    rd(3'd0, 8'hFB, "R2 readback");
    chk({7'd0, irq_out}, 8'd1, "R3 raised");
    // R7 ack with upper bits set, index 2
    cyc(1'b1, 3'd4, 8'hF2, 8'h00, 8'h00, "R7 ack");
    rd(3'd2, 8'h20, "R7 pend");
    chk({7'd0, irq_out}, 8'd0, "R3 dropped");
    // R7 index 9 clears nothing
    cyc(1'b1, 3'd4, 8'h09, 8'h00, 8'h00, "R7 idx9");
    rd(3'd2, 8'h20, "R7 idx9 pend");
    // R6 set vs clear and set vs ack
    cyc(1'b0, 3'd0, 8'h00, 8'h01, 8'h21, "R6 set/clr");
    rd(3'd2, 8'h01, "R6 pend");
    cyc(1'b1, 3'd4, 8'h00, 8'h01, 8'h00, "R6 set/ack");
    rd(3'd2, 8'h01, "R6 ack pend");
    // R5 clear
    cyc(1'b0, 3'd0, 8'h00, 8'h00, 8'h01, "R5 clr");
    rd(3'd2, 8'h00, "R5 pend");
    // R9 secondary mask
    cyc(1'b0, 3'd0, 8'h00, 8'h80, 8'h00, "R9 setup");
    cyc(1'b1, 3'd1, 8'h00, 8'h00, 8'h00, "R9 sec write");
    rd(3'd1, 8'hFF, "R9 sec read");
    rd(3'd0, 8'hFB, "R9 mask intact");
    chk({7'd0, irq_out}, 8'd0, "R9 no irq");
    cyc(1'b1, 3'd1, 8'h5A, 8'h00, 8'h00, "R9 sec write2");
    rd(3'd1, 8'hA5, "R9 sec read2");
    // R8 secondary status
    rd(3'd3, 8'h00, "R8 stat2");
    // R10 unmapped
    for (int a = 5; a < 8; a++) begin
      cyc(1'b1, 3'(a), 8'h00, 8'h00, 8'h00, "R10 write");
      rd(3'(a), 8'h00, "R10 read");
    end
    rd(3'd4, 8'h00, "R10 ack read");
    rd(3'd0, 8'hFB, "R10 mask");
    rd(3'd2, 8'h80, "R10 pend");

    // random traffic
    void'($urandom(seed));
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      logic [7:0] d, s, c;
      logic we;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      s = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      c = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      we = ($urandom_range(0, 1) == 1);
      cyc(we, a, d, s, c, "R3 random");
      if (i % 3 == 0) begin
        rd(3'd2, m_pend, "R8 random pend");
        rd(3'd0, ~m_en, "R2 random mask");
        rd(3'd1, ~m_sec, "R9 random sec");
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule